// File: doc/BRIEF.md
# Bus-Inverting Data Phase Transmitter

This block drives the data phase of a 64-bit shared data bus whose pins are all active-low. Each word arrives on a valid/ready interface with a last-word marker. The transmitter splits the word into four 16-bit lanes and codes each lane separately. A lane is sent complemented, and its lane flag is raised, when sending it unchanged would toggle more than half of that lane's pins. The toggle count is taken against the pin levels the bus carried on the previous transfer. This keeps the number of switching lines per lane at eight or fewer.

While the transmitter owns the data bus it holds an ownership (busy) pin asserted. It pulses a per-transfer valid-data (ready) pin on every clock that carries a new word. When upstream has no word, idle clocks fall between words: the data pins hold, the ready pin stays deasserted, and the busy pin stays asserted. A matching receive decoder, `dbi_rx_dec`, samples the bus on ready clocks and undoes the lane complement. It is used by the testbench to check the round trip.

Top module: `dbi_data_tx`

## Requirements
- R1: Lane k (k = 0..3) covers data bits 16k+15 down to 16k. Its flag is `bus_inv_n[k]`, so flag 0 covers bits 15:0 and flag 3 covers bits 63:48.
- R2: A lane is complemented when more than 8 of its 16 pins would change level relative to the previous transfer. A change of exactly 8 pins does not complement the lane. After coding, no lane toggles more than 8 pins between transfers.
- R3: All pins are active-low. For an uncomplemented lane the pins equal the bitwise inverse of the data and the flag pin is high. For a complemented lane the pins equal the data and the flag pin is low.
- R4: The reference for the toggle count is the pin pattern last driven in each lane, including any complement. It changes only on transfers. After reset it is all pins high.
- R5: While reset is asserted (synchronous, active-high), and on the clock after it is released, all data and flag pins are high, `bus_busy_n` and `bus_rdy_n` are high, and `in_ready` is high.
- R6: A word accepted on a rising edge (`in_valid` and `in_ready` both high) is on the pins, with `bus_rdy_n` low, for the clock that follows that edge.
- R7: `bus_busy_n` goes low on the same clock as the first word's `bus_rdy_n`. It stays low through idle clocks until the last word has been transferred.
- R8: On the clock when the last word is on the bus, `in_ready` is low. On the next clock `bus_busy_n` returns high and `in_ready` returns high.
- R9: On a clock with no accepted word, `bus_rdy_n` is high and the data and flag pins keep their previous levels.
- R10: The decoder raises `out_valid` on the clock after each clock where `bus_rdy_n` is low, and at no other time. Its `out_data` then equals the transmitted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Transmitter can accept a word |
| in_data | input | 64 | Upstream data word |
| in_last | input | 1 | Marks the final word of a burst |
| bus_d_n | output | 64 | Active-low data pins |
| bus_inv_n | output | 4 | Active-low lane complement flags |
| bus_busy_n | output | 1 | Active-low data bus ownership |
| bus_rdy_n | output | 1 | Active-low valid-data strobe |

## Verification
The pins, the flags and the ready strobe are due one clock after the accepting edge. The decoder output is due one clock after that. The busy release and the restored `in_ready` are due on the clock after the last word's bus clock. The bench drives inputs on falling edges and samples at the following falling edge, so each result is read exactly one register stage after its cause. The bench predicts pin levels arithmetically from its own copy of the reference pattern. Its sweep steps every lane through toggle counts 0 to 16, with a different count in each lane, and includes all-8 and all-9 words back to back.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

    localparam int LANE_W_DEF  = 16;
    localparam int LANE_N_DEF  = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OWN  = 2'd1,
        PH_LAST = 2'd2
    } phase_e;

    // largest toggle count that is sent without complement
    function automatic int toggle_limit(input int width);
        return width / 2;
    endfunction

endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc
    import dbi_pkg::*;
#(
    parameter int W = LANE_W_DEF
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] prev_pins_n,
    output logic [W-1:0] pins_n,
    output logic         inv
);
    localparam int CNT_W = $clog2(W + 1);
    localparam int LIMIT = toggle_limit(W);

    logic [W-1:0]     diff;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        // uncomplemented pins would be ~raw; compare against held pins
        diff = (~raw) ^ prev_pins_n;
        cnt  = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CNT_W'(diff[i]);
        end
        inv    = (int'(cnt) > LIMIT);
        pins_n = inv ? raw : ~raw;
    end

endmodule

// File: rtl/dbi_phase_ctrl.sv
module dbi_phase_ctrl
    import dbi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_last,
    output logic in_ready,
    output logic accept,
    output logic busy_n,
    output logic rdy_n
);
    phase_e state;
    logic   rdy_q;

    always_comb begin
        in_ready = (state != PH_LAST);
        accept   = in_valid && in_ready;
        busy_n   = (state == PH_IDLE);
        rdy_n    = rdy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_IDLE;
            rdy_q <= 1'b1;
        end else begin
            rdy_q <= ~accept;
            if (accept) begin
                state <= in_last ? PH_LAST : PH_OWN;
            end else if (state == PH_LAST) begin
                state <= PH_IDLE;
            end
        end
    end

    AST_BUSY_COVERS_RDY: assert property (@(posedge clk) disable iff (rst)
        !rdy_n |-> !busy_n); // R7

    AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (accept && in_last) |=> ##1 (busy_n && in_ready)); // R8

    AST_TAIL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (accept && in_last) |=> !in_ready); // R8

endmodule

// File: rtl/dbi_rx_dec.sv
module dbi_rx_dec
    import dbi_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF,
    parameter int LANE_N = LANE_N_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANE_W*LANE_N-1:0] bus_d_n,
    input  logic [LANE_N-1:0]        bus_inv_n,
    input  logic                     bus_rdy_n,
    output logic                     out_valid,
    output logic [LANE_W*LANE_N-1:0] out_data
);
    localparam int BUS_W = LANE_W * LANE_N;

    logic [BUS_W-1:0] dec;

    for (genvar g = 0; g < LANE_N; g++) begin : g_lane
        assign dec[g*LANE_W +: LANE_W] = bus_inv_n[g] ? ~bus_d_n[g*LANE_W +: LANE_W]
                                                      :  bus_d_n[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ~bus_rdy_n;
            if (!bus_rdy_n) begin
                out_data <= dec;
            end
        end
    end

    AST_RX_VALID_ON_RDY: assert property (@(posedge clk) disable iff (rst)
        !bus_rdy_n |=> out_valid); // R10

    AST_RX_QUIET_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
        bus_rdy_n |=> !out_valid); // R10

endmodule

// File: rtl/dbi_data_tx.sv
module dbi_data_tx
    import dbi_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF,
    parameter int LANE_N = LANE_N_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [LANE_W*LANE_N-1:0] in_data,
    input  logic                     in_last,
    output logic [LANE_W*LANE_N-1:0] bus_d_n,
    output logic [LANE_N-1:0]        bus_inv_n,
    output logic                     bus_busy_n,
    output logic                     bus_rdy_n
);
    localparam int BUS_W = LANE_W * LANE_N;
    localparam int LIMIT = toggle_limit(LANE_W);

    logic              accept;
    logic [BUS_W-1:0]  pins_q;
    logic [LANE_N-1:0] inv_n_q;
    logic [BUS_W-1:0]  pins_nxt;
    logic [LANE_N-1:0] inv_nxt;

    dbi_phase_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_ready (in_ready),
        .accept   (accept),
        .busy_n   (bus_busy_n),
        .rdy_n    (bus_rdy_n)
    );

    for (genvar g = 0; g < LANE_N; g++) begin : g_lane
        dbi_lane_enc #(.W(LANE_W)) u_enc (
            .raw         (in_data[g*LANE_W +: LANE_W]),
            .prev_pins_n (pins_q[g*LANE_W +: LANE_W]),
            .pins_n      (pins_nxt[g*LANE_W +: LANE_W]),
            .inv         (inv_nxt[g])
        );

        AST_LANE_TOGGLE_CAP: assert property (@(posedge clk) disable iff (rst)
            !bus_rdy_n |-> ($countones(pins_q[g*LANE_W +: LANE_W]
                            ^ $past(pins_q[g*LANE_W +: LANE_W])) <= LIMIT)); // R2
    end

    // pin register doubles as the per-lane toggle reference
    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q  <= '1;
            inv_n_q <= '1;
        end else if (accept) begin
            pins_q  <= pins_nxt;
            inv_n_q <= ~inv_nxt;
        end
    end

    assign bus_d_n   = pins_q;
    assign bus_inv_n = inv_n_q;

    logic [BUS_W-1:0] restored;
    for (genvar g = 0; g < LANE_N; g++) begin : g_chk
        assign restored[g*LANE_W +: LANE_W] = inv_n_q[g] ? ~pins_q[g*LANE_W +: LANE_W]
                                                         :  pins_q[g*LANE_W +: LANE_W];
    end

    AST_WORD_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (restored == $past(in_data))); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> ($stable(pins_q) && $stable(inv_n_q) && bus_rdy_n)); // R9

endmodule

// File: tb/tb_dbi_data_tx.sv
module tb_dbi_data_tx;
    localparam int CLK_PERIOD = 10;
    localparam int GW = 16;
    localparam int NG = 4;
    localparam int BW = GW * NG;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [BW-1:0] in_data = '0;
    logic          in_last = 1'b0;
    logic [BW-1:0] bus_d_n;
    logic [NG-1:0] bus_inv_n;
    logic          bus_busy_n;
    logic          bus_rdy_n;
    logic          rx_valid;
    logic [BW-1:0] rx_data;

    dbi_data_tx #(.LANE_W(GW), .LANE_N(NG)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .bus_d_n(bus_d_n),
        .bus_inv_n(bus_inv_n), .bus_busy_n(bus_busy_n), .bus_rdy_n(bus_rdy_n)
    );

    dbi_rx_dec #(.LANE_W(GW), .LANE_N(NG)) u_rx (
        .clk(clk), .rst(rst), .bus_d_n(bus_d_n), .bus_inv_n(bus_inv_n),
        .bus_rdy_n(bus_rdy_n), .out_valid(rx_valid), .out_data(rx_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done = 1'b0;
    logic [BW-1:0] ref_pins = '1;
    logic [NG-1:0] ref_inv_n = '1;
    logic [BW-1:0] exp_q [0:1023];
    int            wr_i = 0;
    int            rd_i = 0;
    logic [63:0]   lfsr = 64'h9E37_79B9_7F4A_7C15;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // reference model of lane coding, built from R2..R4
    task automatic predict(input logic [BW-1:0] d);
        for (int g = 0; g < NG; g++) begin
            logic [GW-1:0] raw;
            logic [GW-1:0] prevl;
            int            cnt;
            raw   = d[g*GW +: GW];
            prevl = ~ref_pins[g*GW +: GW];
            cnt   = $countones(raw ^ prevl);
            if (cnt > GW/2) begin
                ref_pins[g*GW +: GW] = raw;
                ref_inv_n[g] = 1'b0;
            end else begin
                ref_pins[g*GW +: GW] = ~raw;
                ref_inv_n[g] = 1'b1;
            end
        end
    endtask

    // call at a falling edge; returns at the falling edge after the transfer clock
    task automatic drive(input logic [BW-1:0] d, input bit last);
        check(in_ready === 1'b1, "R8", "in_ready before word", 64'(in_ready), 64'd1);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        predict(d);
        exp_q[wr_i[9:0]] = d;
        wr_i++;
        for (int g = 0; g < NG; g++) begin
            check(bus_d_n[g*GW +: GW] === ref_pins[g*GW +: GW], "R1 R2 R3 R4", "lane pins",
                  64'(bus_d_n[g*GW +: GW]), 64'(ref_pins[g*GW +: GW]));
            check(bus_inv_n[g] === ref_inv_n[g], "R1 R2", "lane flag",
                  64'(bus_inv_n[g]), 64'(ref_inv_n[g]));
        end
        check(bus_rdy_n === 1'b0, "R6", "ready strobe", 64'(bus_rdy_n), 64'd0);
        check(bus_busy_n === 1'b0, "R7", "busy during word", 64'(bus_busy_n), 64'd0);
        if (last) begin
            check(in_ready === 1'b0, "R8", "in_ready on last word", 64'(in_ready), 64'd0);
            @(negedge clk);
            check(bus_busy_n === 1'b1, "R8", "busy released", 64'(bus_busy_n), 64'd1);
            check(bus_rdy_n === 1'b1, "R9", "ready after last", 64'(bus_rdy_n), 64'd1);
        end
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(bus_rdy_n === 1'b1, "R9", "ready on idle clock", 64'(bus_rdy_n), 64'd1);
            check(bus_d_n === ref_pins, "R9", "pins hold on idle clock", bus_d_n, ref_pins);
            check(bus_inv_n === ref_inv_n, "R9", "flags hold on idle clock",
                  64'(bus_inv_n), 64'(ref_inv_n));
            check(bus_busy_n === 1'b0, "R7", "busy across idle clock", 64'(bus_busy_n), 64'd0);
        end
    endtask

    // word whose lane g toggles exactly cnt[g] pins (before coding) against reference
    function automatic logic [BW-1:0] make_word(input int c0, input int c1, input int c2,
                                                input int c3, input int rot);
        logic [BW-1:0] w;
        int            cs [NG];
        cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3;
        for (int g = 0; g < NG; g++) begin
            logic [GW-1:0] m;
            m = '0;
            for (int b = 0; b < cs[g]; b++) m[b] = 1'b1;
            for (int r = 0; r < rot; r++) m = {m[GW-2:0], m[GW-1]};
            w[g*GW +: GW] = (~ref_pins[g*GW +: GW]) ^ m;
        end
        return w;
    endfunction

    initial begin : rx_monitor
        forever begin
            @(negedge clk);
            if (!rst && rx_valid) begin
                check(rd_i < wr_i, "R10", "decoder valid without transfer",
                      64'(rd_i), 64'(wr_i));
                if (rd_i < wr_i) begin
                    check(rx_data === exp_q[rd_i[9:0]], "R10", "decoded word",
                          rx_data, exp_q[rd_i[9:0]]);
                end
                rd_i++;
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(bus_d_n === '1, "R5", "reset data pins", bus_d_n, '1);
        check(bus_inv_n === '1, "R5", "reset flags", 64'(bus_inv_n), 64'hF);
        check(bus_busy_n === 1'b1, "R5", "reset busy", 64'(bus_busy_n), 64'd1);
        check(bus_rdy_n === 1'b1, "R5", "reset ready", 64'(bus_rdy_n), 64'd1);
        check(in_ready === 1'b1, "R5", "reset in_ready", 64'(in_ready), 64'd1);
        check(rx_valid === 1'b0, "R5", "reset decoder", 64'(rx_valid), 64'd0);

        // sweep of toggle counts 0..16, different per lane, bursts with gaps
        for (int k = 0; k <= 16; k++) begin
            bit last;
            last = (k % 4 == 3) || (k == 16);
            drive(make_word(k % 17, (k + 4) % 17, (k + 9) % 17, (k + 13) % 17, k % GW), last);
            if (!last) gap(k % 3);
        end

        // exactly 8 (kept) then exactly 9 (complemented), back to back
        drive(make_word(8, 8, 8, 8, 3), 1'b0);
        drive(make_word(9, 9, 9, 9, 5), 1'b0);
        drive(make_word(8, 9, 8, 9, 7), 1'b0);
        gap(2);
        drive(make_word(9, 8, 9, 8, 1), 1'b1);

        // pseudo-random words with random gaps and burst ends
        for (int n = 0; n < 300; n++) begin
            bit last;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 7);
            lfsr = lfsr ^ (lfsr << 17);
            last = (lfsr[3:0] == 4'd0) || (n == 299);
            drive(lfsr, last);
            if (!last) gap(int'(lfsr[5:4]) % 3);
        end

        repeat (3) @(negedge clk);
        check(rd_i == wr_i, "R10", "decoded word count", 64'(rd_i), 64'(wr_i));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule